// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This unit turns up to 32 general-purpose input lines into grouped interrupt requests. The input pins are synchronised, and each line is XORed with a per-line polarity bit supplied by the pin-control logic. The resulting adjusted value feeds two paths. The edge path latches every inactive-to-active transition into a shared cause register, which software acknowledges by writing zeros. The level path uses the adjusted value directly as its cause.

Each processor owns an edge mask and a level mask. A line requests service when its masked edge cause or its masked level value is set. The per-line requests of each processor are ORed in groups of eight consecutive lines, so every processor gets one interrupt output per group.

The number of processors (1, 2 or 4) is a build parameter that selects the register layout. A one- or two-processor build decodes only the main region. A four-processor build adds a second region that holds per-processor windows. Any offset that the selected layout does not implement reads as zero and ignores writes.

Top module: `gpio_irq_unit`

## Requirements
- R1: The cause bit of a line is set, two clock edges after the synchronised line reaches the register stage, when its adjusted value (line XOR polarity) goes from 0 to 1. With polarity 0 this captures a rising pin edge, and with polarity 1 a falling pin edge. The opposite pin edge sets nothing.
- R2: A write to the cause register (main region, offset 0x14) clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R3: When an edge event and a clearing cause write reach the same bit in the same cycle, the bit ends up set.
- R4: The level request of a line is its current adjusted value gated by a processor's level mask. It follows the pin with no latching, and polarity 1 makes a low pin active.
- R5: The request of a line for a processor is (adjusted value AND level mask) OR (cause AND edge mask). With both masks zero, that processor's outputs stay low whatever the cause holds.
- R6: Output bit irqOut[cpu*GROUPS + g] is the registered OR of the requests of lines 8g to 8g+7 for that processor, where GROUPS = ceil(NUM_LINES/8).
- R7: After reset the cause register and all masks read zero and every interrupt output is low.
- R8: In the two-processor layout, processor 0 uses the edge and level masks at main offsets 0x18 and 0x1C. Processor 1 uses an edge mask at 0x30 and a level mask at 0x34. Each processor drives its own set of outputs.
- R9: In the four-processor layout, the per-processor region (regRegion=1) aliases the shared cause at cpu*4 and holds processor cpu's edge mask at 0x10+cpu*4 and level mask at 0x20+cpu*4. Main offsets 0x18 and 0x1C alias processor 0's masks.
- R10: An access to an offset the selected layout lacks reads zero and changes no state. This covers 0x30 and 0x34 outside the two-processor layout and the whole per-processor region outside the four-processor layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lineIn | input | NUM_LINES | Asynchronous line inputs |
| polarity | input | NUM_LINES | Per-line inversion (1 = active low) |
| regWrEn | input | 1 | Register write strobe |
| regRegion | input | 1 | 0 = main region, 1 = per-processor region |
| regAddr | input | 8 | Byte offset within the selected region |
| regWrData | input | NUM_LINES | Write data |
| regRdData | output | NUM_LINES | Combinational read data for regRegion/regAddr |
| irqOut | output | NUM_CPUS*GROUPS | Grouped interrupt outputs, processor-major |

## Verification
The bench builds two copies that share one stimulus bus. One copy uses 32 lines with four processors, and the other uses 32 lines with two processors. A single write therefore lands on two different layouts. The bench can show that offsets 0x30/0x34 hold processor-1 masks in one copy and read zero in the other, and that the per-processor region exists in only one copy. With 32 lines, all four groups can be reached, including the top group. The set-versus-clear race is timed cycle-exactly against the two-stage synchroniser.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MAX_CPUS = 4;
  localparam int LINES_PER_GROUP = 8;

  localparam logic [7:0] OFF_CAUSE      = 8'h14;
  localparam logic [7:0] OFF_EDGE_CPU0  = 8'h18;
  localparam logic [7:0] OFF_LEVEL_CPU0 = 8'h1C;
  localparam logic [7:0] OFF_EDGE_CPU1  = 8'h30;
  localparam logic [7:0] OFF_LEVEL_CPU1 = 8'h34;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_EDGE  = 2'd2,
    RD_LEVEL = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                causeWr;
    logic [MAX_CPUS-1:0] edgeMaskWr;
    logic [MAX_CPUS-1:0] levelMaskWr;
    rdSel_e              rdSel;
    logic [1:0]          rdCpu;
  } regStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic       regWrEn,
  input  logic       regRegion,
  input  logic [7:0] regAddr,
  output regStrobe_t strobe
);
  rdSel_e     sel;
  logic [1:0] cpuIdx;

  always_comb begin
    sel    = RD_NONE;
    cpuIdx = 2'd0;
    if (!regRegion) begin
      if (regAddr == OFF_CAUSE) begin
        sel = RD_CAUSE;
      end else if (regAddr == OFF_EDGE_CPU0) begin
        sel = RD_EDGE;
      end else if (regAddr == OFF_LEVEL_CPU0) begin
        sel = RD_LEVEL;
      end else if (NUM_CPUS == 2 && regAddr == OFF_EDGE_CPU1) begin
        sel    = RD_EDGE;
        cpuIdx = 2'd1;
      end else if (NUM_CPUS == 2 && regAddr == OFF_LEVEL_CPU1) begin
        sel    = RD_LEVEL;
        cpuIdx = 2'd1;
      end
    end else if (NUM_CPUS == 4 && regAddr[1:0] == 2'b00) begin
      cpuIdx = regAddr[3:2];
      case (regAddr[7:4])
        4'h0:    sel = RD_CAUSE;
        4'h1:    sel = RD_EDGE;
        4'h2:    sel = RD_LEVEL;
        default: sel = RD_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.rdSel       = sel;
    strobe.rdCpu       = cpuIdx;
    strobe.causeWr     = regWrEn && (sel == RD_CAUSE);
    strobe.edgeMaskWr  = (regWrEn && sel == RD_EDGE)  ? (MAX_CPUS'(1) << cpuIdx) : '0;
    strobe.levelMaskWr = (regWrEn && sel == RD_LEVEL) ? (MAX_CPUS'(1) << cpuIdx) : '0;
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_CPUS  = 4,
  parameter int GROUPS    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINES-1:0]       lineIn,
  input  logic [NUM_LINES-1:0]       polarity,
  input  regStrobe_t                 strobe,
  input  logic [NUM_LINES-1:0]       wrData,
  output logic [NUM_LINES-1:0]       rdData,
  output logic [NUM_CPUS*GROUPS-1:0] irqOut
);
  localparam int PADDED = GROUPS * LINES_PER_GROUP;

  logic [NUM_LINES-1:0] syncA, syncB, prevAdj, causeQ;
  logic [NUM_LINES-1:0] adjIn, edgeEv;
  logic [NUM_LINES-1:0] edgeMaskQ  [NUM_CPUS];
  logic [NUM_LINES-1:0] levelMaskQ [NUM_CPUS];
  logic [GROUPS-1:0]    irqGrpQ    [NUM_CPUS];

  assign adjIn  = syncB ^ polarity;
  assign edgeEv = adjIn & ~prevAdj;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= '0;
      syncB   <= '0;
      prevAdj <= '0;
      causeQ  <= '0;
    end else begin
      syncA   <= lineIn;
      syncB   <= syncA;
      prevAdj <= adjIn;
      causeQ  <= (strobe.causeWr ? (causeQ & wrData) : causeQ) | edgeEv;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [PADDED-1:0] lineReq;
    logic [GROUPS-1:0] grpReq;

    always_ff @(posedge clk) begin
      if (rst) begin
        edgeMaskQ[c]  <= '0;
        levelMaskQ[c] <= '0;
        irqGrpQ[c]    <= '0;
      end else begin
        if (strobe.edgeMaskWr[c])  edgeMaskQ[c]  <= wrData;
        if (strobe.levelMaskWr[c]) levelMaskQ[c] <= wrData;
        irqGrpQ[c] <= grpReq;
      end
    end

    always_comb begin
      lineReq = PADDED'((adjIn & levelMaskQ[c]) | (causeQ & edgeMaskQ[c]));
      for (int g = 0; g < GROUPS; g++) begin
        grpReq[g] = |lineReq[g*LINES_PER_GROUP +: LINES_PER_GROUP];
      end
    end

    assign irqOut[c*GROUPS +: GROUPS] = irqGrpQ[c];

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (edgeMaskQ[c] == '0 && levelMaskQ[c] == '0) |=> (irqGrpQ[c] == '0)); // R5
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_CAUSE: rdData = causeQ;
      RD_EDGE: begin
        for (int c = 0; c < NUM_CPUS; c++) begin
          if (strobe.rdCpu == 2'(c)) rdData = edgeMaskQ[c];
        end
      end
      RD_LEVEL: begin
        for (int c = 0; c < NUM_CPUS; c++) begin
          if (strobe.rdCpu == 2'(c)) rdData = levelMaskQ[c];
        end
      end
      default: rdData = '0;
    endcase
  end

  AST_CAUSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (causeQ & ~$past(causeQ) & ~$past(edgeEv)) == '0); // R1

  AST_ONE_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    strobe.causeWr |=> ((($past(causeQ) & $past(wrData)) & ~causeQ) == '0)); // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (strobe.causeWr && edgeEv != '0) |=> ((causeQ & $past(edgeEv)) == $past(edgeEv))); // R3

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (causeQ == '0 && irqOut == '0)); // R7
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_CPUS  = 4,
  localparam int GROUPS   = (NUM_LINES + LINES_PER_GROUP - 1) / LINES_PER_GROUP
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LINES-1:0]       lineIn,
  input  logic [NUM_LINES-1:0]       polarity,
  input  logic                       regWrEn,
  input  logic                       regRegion,
  input  logic [7:0]                 regAddr,
  input  logic [NUM_LINES-1:0]       regWrData,
  output logic [NUM_LINES-1:0]       regRdData,
  output logic [NUM_CPUS*GROUPS-1:0] irqOut
);
  regStrobe_t strobe;

  gpio_irq_ctrl #(.NUM_CPUS(NUM_CPUS)) ctrl_i (
    .regWrEn  (regWrEn),
    .regRegion(regRegion),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  gpio_irq_dp #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .GROUPS(GROUPS)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .lineIn  (lineIn),
    .polarity(polarity),
    .strobe  (strobe),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );

  AST_ABSENT_REGION_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regRegion && NUM_CPUS != 4) |-> (regRdData == '0)); // R10
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb_top;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] lineIn = '0;
  logic [N-1:0] polarity = '0;
  logic         regWrEn = 1'b0;
  logic         regRegion = 1'b0;
  logic [7:0]   regAddr = '0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] rdA, rdB;
  logic [15:0]  irqA;
  logic [7:0]   irqB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_unit #(.NUM_LINES(N), .NUM_CPUS(4)) dut_i (
    .clk(clk), .rst(rst), .lineIn(lineIn), .polarity(polarity),
    .regWrEn(regWrEn), .regRegion(regRegion), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdA), .irqOut(irqA));

  gpio_irq_unit #(.NUM_LINES(N), .NUM_CPUS(2)) dut2_i (
    .clk(clk), .rst(rst), .lineIn(lineIn), .polarity(polarity),
    .regWrEn(regWrEn), .regRegion(regRegion), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdB), .irqOut(irqB));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic region, input logic [7:0] addr, input logic [N-1:0] data);
    @(negedge clk);
    regRegion = region; regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic region, input logic [7:0] addr,
                    output logic [N-1:0] a, output logic [N-1:0] b);
    @(negedge clk);
    regRegion = region; regAddr = addr;
    #2;
    a = rdA; b = rdB;
  endtask

  task automatic cleanup();
    lineIn = '0;
    tick(5);
    polarity = '0;
    tick(5);
    wr(0, 8'h18, '0); wr(0, 8'h1C, '0); wr(0, 8'h30, '0); wr(0, 8'h34, '0);
    for (int c = 0; c < 4; c++) begin
      wr(1, 8'(8'h10 + c*4), '0);
      wr(1, 8'(8'h20 + c*4), '0);
    end
    wr(0, 8'h14, '0);
    tick(2);
  endtask

  task automatic t_reset();
    logic [N-1:0] a, b;
    rd(0, 8'h14, a, b); chk("R7", "cause after reset", a, 0);
    rd(0, 8'h18, a, b); chk("R7", "edge mask after reset", a, 0);
    rd(0, 8'h1C, a, b); chk("R7", "level mask after reset", b, 0);
    rd(1, 8'h28, a, b); chk("R7", "cpu2 level mask after reset", a, 0);
    chk("R7", "outputs after reset", {irqB, irqA}, 0);
  endtask

  task automatic t_edge();
    logic [N-1:0] a, b;
    lineIn[3] = 1'b1; tick(5);
    rd(0, 8'h14, a, b); chk("R1", "rising edge latched (pol 0)", {b, a}, {32'h8, 32'h8});
    chk("R5", "unmasked cause stays silent", {irqB, irqA}, 0);
    wr(0, 8'h18, 32'h8); tick(2);
    chk("R5", "edge mask passes cause cpu0", irqA, 16'h0001);
    chk("R6", "group0 on two-cpu copy", irqB, 8'h01);
    lineIn[5] = 1'b1; tick(5);
    rd(0, 8'h14, a, b); chk("R1", "second edge latched", a, 32'h28);
    wr(0, 8'h14, ~32'h8); tick(1);
    rd(0, 8'h14, a, b); chk("R2", "zero clears, one keeps", a, 32'h20);
    tick(1);
    chk("R2", "acknowledged line drops irq", irqA, 16'h0000);
    lineIn[3] = 1'b0; tick(5);
    rd(0, 8'h14, a, b); chk("R1", "falling pin with pol 0 sets nothing", a, 32'h20);
    cleanup();
  endtask

  task automatic t_fall();
    logic [N-1:0] a, b;
    lineIn[9] = 1'b1; tick(5);
    wr(0, 8'h14, '0);
    polarity[9] = 1'b1; tick(5);
    rd(0, 8'h14, a, b); chk("R1", "inactive-going change sets nothing", a, 0);
    lineIn[9] = 1'b0; tick(5);
    rd(0, 8'h14, a, b); chk("R1", "falling edge latched (pol 1)", a, 32'h200);
    wr(0, 8'h14, '0);
    lineIn[9] = 1'b1; tick(5);
    rd(0, 8'h14, a, b); chk("R1", "rising pin with pol 1 sets nothing", a, 0);
    cleanup();
  endtask

  task automatic t_level();
    wr(0, 8'h1C, 32'h1000);
    lineIn[12] = 1'b1; tick(5);
    chk("R4", "level high raises group1", irqA, 16'h0002);
    lineIn[12] = 1'b0; tick(5);
    chk("R4", "level follows pin low", irqA, 16'h0000);
    polarity[12] = 1'b1; tick(5);
    chk("R4", "active-low level with pol 1", irqA, 16'h0002);
    cleanup();
  endtask

  task automatic t_groups_and_cpus();
    logic [N-1:0] a, b;
    wr(0, 8'h1C, 32'h4000_0080);
    lineIn[30] = 1'b1; tick(5);
    chk("R6", "line 30 maps to group 3", irqA, 16'h0008);
    lineIn[7] = 1'b1; tick(5);
    chk("R6", "line 7 maps to group 0", irqA, 16'h0009);
    chk("R6", "two-cpu copy groups", irqB, 8'h09);
    wr(1, 8'h24, 32'h4000_0000); tick(2);
    chk("R9", "cpu1 level mask drives its outputs", irqA, 16'h0089);
    rd(1, 8'h24, a, b);
    chk("R9", "cpu1 level mask readback", a, 32'h4000_0000);
    chk("R10", "per-cpu region absent in two-cpu copy", b, 0);
    rd(1, 8'h04, a, b); chk("R9", "per-cpu cause alias", a, 32'h4000_0080);
    rd(1, 8'h20, a, b); chk("R9", "cpu0 level alias of main 0x1C", a, 32'h4000_0080);
    wr(0, 8'h34, 32'h80); tick(2);
    chk("R8", "cpu1 level mask at 0x34", irqB, 8'h19);
    chk("R10", "0x34 write ignored by four-cpu copy", irqA, 16'h0089);
    rd(0, 8'h34, a, b);
    chk("R8", "0x34 readback two-cpu", b, 32'h80);
    chk("R10", "0x34 reads zero four-cpu", a, 0);
    wr(0, 8'h30, 32'h4000_0000); tick(2);
    chk("R8", "cpu1 edge mask at 0x30", irqB, 8'h99);
    cleanup();
  endtask

  task automatic t_set_wins();
    logic [N-1:0] a, b;
    @(negedge clk);
    lineIn[20] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regRegion = 1'b0; regAddr = 8'h14; regWrData = '0; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(0, 8'h14, a, b); chk("R3", "set wins over same-cycle clear", a, 32'h0010_0000);
    wr(0, 8'h14, '0);
    rd(0, 8'h14, a, b); chk("R2", "later clear takes effect", a, 0);
    cleanup();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_edge();
    t_fall();
    t_level();
    t_groups_and_cpus();
    t_set_wins();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule